// File: doc/BRIEF.md
# Bus Address Decoder with Phase-2 Strobe Qualification

This block decodes the 16-bit address of an 8-bit microprocessor backplane into selects for the devices on one board: a 512-byte system ROM, a serial controller, a monitor EEPROM, a spare ROM socket, a read-only keyboard port, two banks of graphics RAM, character RAM and main RAM. Chip-enables come from the address alone, so a device is selected early in the bus cycle. Output-enables, write strobes and the data-direction request are gated by the phase-2 clock and by the read/write line, so they only open once the address has settled.

The block samples the bus on a fast local clock and registers every output. Each output therefore shows the decode of the inputs seen at the previous rising edge. The data-direction request is modelled as an open-drain pull: a 1 means this board pulls the shared line, and the backplane forms the wired-OR across all boards. Data crossing the board's inverting buffer is inverted in both directions.

Top module: `addr_strobe_decoder`

## Requirements
- R1: Active-low chip-enable bit `ce_n[i]` goes low for exactly one region, and no more than one bit is ever low. The bits are: 0 for system ROM FE00–FFFF, 1 for serial controller FC00–FCFF, 2 for monitor EEPROM E000–E3FF, 3 for spare ROM E400–E7FF, 4 for keyboard DC00–DFFF, 5 for graphics RAM D400–DBFF, 6 for character RAM D000–D3FF, and 7 for main RAM 0000–0FFF. All outputs appear one clock after the inputs are sampled.
- R2: The chip-enable depends only on the address. It is the same for every combination of `phi2` and `rw`.
- R3: `oe_n[i]` is low only when region i is selected, `phi2` is 1 and `rw` is 1 (read).
- R4: `we_n[i]` is low only when region i is selected, `phi2` is 1, `rw` is 0 (write), and region i is writable. The writable regions are bits 1, 5, 6 and 7. Writes to the keyboard or to any ROM produce no strobe.
- R5: An address outside every region (for example 1000–CFFF, E800–FBFF or FD00–FDFF) leaves all `ce_n`, `oe_n` and `we_n` high. In that case `dir_pull` stays 0 and `buf_en_n` stays 1.
- R6: `dir_pull` is 1 exactly when an address hits a region while `phi2` is 1 and `rw` is 1.
- R7: `buf_en_n` is low exactly when an address hits a region while `phi2` is 1.
- R8: `bus_rdata` equals the bitwise inverse of `loc_rdata` during a qualified read hit. At all other times it is all ones, which is the released bus.
- R9: `loc_wdata` always equals the bitwise inverse of `bus_wdata`.
- R10: `gfx_bank` equals address bit 10 while the graphics region is selected, so D400–D7FF gives 1 and D800–DBFF gives 0. It is 0 at any other address.
- R11: While `rst_n` is low at a clock edge, every strobe is inactive, `dir_pull` and `gfx_bank` are 0, `bus_rdata` is all ones and `loc_wdata` is zero. This holds whatever the bus inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Backplane address |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2 | input | 1 | Phase-2 bus clock |
| loc_rdata | input | 8 | Read data from the board's devices |
| bus_wdata | input | 8 | Write data from the backplane |
| ce_n | output | 8 | Active-low chip-enables, one per region |
| oe_n | output | 8 | Active-low output-enables, one per region |
| we_n | output | 8 | Active-low write strobes, one per region |
| dir_pull | output | 1 | 1 = pull the shared data-direction line |
| buf_en_n | output | 1 | Active-low enable of the inverting bus buffer |
| gfx_bank | output | 1 | Graphics RAM bank select |
| bus_rdata | output | 8 | Inverted read data toward the backplane |
| loc_wdata | output | 8 | Inverted write data toward the devices |

## Verification
The bench visits both edges of every region and the first address outside each one, in all four combinations of `phi2` and `rw`. These cases catch decoders whose range is off by one: such a decoder selects a neighbour or drops the last byte of a ROM. Writes to the keyboard and to the ROMs are aimed at the strobes. A decoder that forgets the read-only mask fires `we_n` there. A decoder that gates the select with phase-2 loses `ce_n` in phase 1. The graphics bank edge at D7FF/D800 exposes a bank bit taken from the wrong address line. Reads in phase 1 show a direction request or buffer enable that was not qualified by phase-2.

// File: rtl/busdec_pkg.sv
// Package: region table and shared constants for the board address decoder.
// Assumes a 16-bit address map. Each region is an inclusive [lo, hi] range;
// ranges do not overlap.
package busdec_pkg;

    localparam int NREG   = 8;
    localparam int MAP_AW = 16;

    // Region indices; each index is also the bit position in the select vectors.
    localparam int IDX_SYSROM = 0;
    localparam int IDX_SERIAL = 1;
    localparam int IDX_MON    = 2;
    localparam int IDX_SPARE  = 3;
    localparam int IDX_KBD    = 4;
    localparam int IDX_GFX    = 5;
    localparam int IDX_CHR    = 6;
    localparam int IDX_RAM    = 7;

    typedef logic [MAP_AW-1:0] maddr_t;

    typedef struct packed {
        maddr_t lo;
        maddr_t hi;
        logic   wr_ok;
    } region_t;

    // Return the bounds and writability of one region.
    function automatic region_t region_at(input int idx);
        region_t r;
        case (idx)
            IDX_SYSROM: r = '{lo: 16'hFE00, hi: 16'hFFFF, wr_ok: 1'b0};
            IDX_SERIAL: r = '{lo: 16'hFC00, hi: 16'hFCFF, wr_ok: 1'b1};
            IDX_MON:    r = '{lo: 16'hE000, hi: 16'hE3FF, wr_ok: 1'b0};
            IDX_SPARE:  r = '{lo: 16'hE400, hi: 16'hE7FF, wr_ok: 1'b0};
            IDX_KBD:    r = '{lo: 16'hDC00, hi: 16'hDFFF, wr_ok: 1'b0};
            IDX_GFX:    r = '{lo: 16'hD400, hi: 16'hDBFF, wr_ok: 1'b1};
            IDX_CHR:    r = '{lo: 16'hD000, hi: 16'hD3FF, wr_ok: 1'b1};
            IDX_RAM:    r = '{lo: 16'h0000, hi: 16'h0FFF, wr_ok: 1'b1};
            default:    r = '{lo: 16'hFFFF, hi: 16'h0000, wr_ok: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/busdec_region_match.sv
// Module: combinational range match of the address against every region.
// Assumes ADDR_W equals the map width. A hit is computed as
// (addr - lo) < span on ADDR_W+1 bits, so an address below lo wraps
// to a large value and misses.
module busdec_region_match #(
    parameter int ADDR_W = 16,
    parameter int NREG   = busdec_pkg::NREG
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit,
    output logic              any_hit
);

    localparam int XW = ADDR_W + 1;

    logic [XW-1:0] addr_x;

    // Widen the address so the subtraction cannot alias.
    always_comb addr_x = {1'b0, addr};

    for (genvar g = 0; g < NREG; g++) begin : g_region
        localparam busdec_pkg::region_t RG = busdec_pkg::region_at(g);
        localparam logic [XW-1:0] LO_X = {1'b0, RG.lo};
        localparam logic [XW-1:0] SPAN = {1'b0, RG.hi} - {1'b0, RG.lo} + XW'(1);

        logic [XW-1:0] offs;

        // Offset of the address from the region base.
        always_comb offs = addr_x - LO_X;

        // A region hits when the offset falls inside its span.
        always_comb hit[g] = (offs < SPAN);
    end

    // Any region on this board is addressed.
    always_comb any_hit = |hit;

endmodule

// File: rtl/busdec_strobe_gen.sv
// Module: registered select and strobe generation.
// Chip-enables follow the address hits unconditionally. Output-enables,
// write strobes, the direction pull and the buffer enable are qualified
// by phi2 and rw. Write strobes exist only for writable regions (chosen
// per region in a generate). Assumes hit is one-hot or zero.
module busdec_strobe_gen #(
    parameter int NREG = busdec_pkg::NREG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] hit,
    input  logic            any_hit,
    input  logic            phi2,
    input  logic            rw,
    output logic [NREG-1:0] ce_n,
    output logic [NREG-1:0] oe_n,
    output logic [NREG-1:0] we_n,
    output logic            dir_pull,
    output logic            buf_en_n
);

    logic            rd_qual;
    logic            wr_qual;
    logic [NREG-1:0] we_nxt;

    // Phase-2 qualified read and write conditions.
    always_comb begin
        rd_qual = phi2 & rw;
        wr_qual = phi2 & ~rw;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_we
        localparam busdec_pkg::region_t RG = busdec_pkg::region_at(g);
        if (RG.wr_ok) begin : g_writable
            // Writable region: strobe on a qualified write hit.
            always_comb we_nxt[g] = ~(hit[g] & wr_qual);
        end else begin : g_readonly
            // Read-only region: the strobe never fires.
            always_comb we_nxt[g] = 1'b1;
        end
    end

    // Register all selects and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n     <= '1;
            oe_n     <= '1;
            we_n     <= '1;
            dir_pull <= 1'b0;
            buf_en_n <= 1'b1;
        end else begin
            ce_n     <= ~hit;
            oe_n     <= ~(hit & {NREG{rd_qual}});
            we_n     <= we_nxt;
            dir_pull <= any_hit & rd_qual;
            buf_en_n <= ~(any_hit & phi2);
        end
    end

endmodule

// File: rtl/busdec_data_invert.sv
// Module: registered model of the inverting data buffer.
// Read data goes out inverted only while this board drives the bus;
// otherwise the bus is released (all ones). Write data comes in
// inverted unconditionally.
module busdec_data_invert #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_drive,
    input  logic [DATA_W-1:0] loc_rdata,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] loc_wdata
);

    // Invert and register both data directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '1;
            loc_wdata <= '0;
        end else begin
            bus_rdata <= rd_drive ? ~loc_rdata : '1;
            loc_wdata <= ~bus_wdata;
        end
    end

endmodule

// File: rtl/addr_strobe_decoder.sv
// Module: top of the board address decoder.
// It samples the bus on clk and registers every output, so outputs lag
// the sampled inputs by one clock. Assumes ADDR_W matches the 16-bit
// region table.
module addr_strobe_decoder #(
    parameter int ADDR_W       = busdec_pkg::MAP_AW,
    parameter int DATA_W       = 8,
    parameter int NREG         = busdec_pkg::NREG,
    parameter int GFX_BANK_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              phi2,
    input  logic [DATA_W-1:0] loc_rdata,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [NREG-1:0]   ce_n,
    output logic [NREG-1:0]   oe_n,
    output logic [NREG-1:0]   we_n,
    output logic              dir_pull,
    output logic              buf_en_n,
    output logic              gfx_bank,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] loc_wdata
);

    logic [NREG-1:0] hit;
    logic            any_hit;
    logic            rd_drive;

    busdec_region_match #(
        .ADDR_W (ADDR_W),
        .NREG   (NREG)
    ) u_match (
        .addr    (addr),
        .hit     (hit),
        .any_hit (any_hit)
    );

    busdec_strobe_gen #(
        .NREG (NREG)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .any_hit  (any_hit),
        .phi2     (phi2),
        .rw       (rw),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .dir_pull (dir_pull),
        .buf_en_n (buf_en_n)
    );

    // This board drives the bus on a qualified read hit.
    always_comb rd_drive = any_hit & phi2 & rw;

    busdec_data_invert #(
        .DATA_W (DATA_W)
    ) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_drive  (rd_drive),
        .loc_rdata (loc_rdata),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .loc_wdata (loc_wdata)
    );

    // Register the graphics bank bit, valid only inside the graphics region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gfx_bank <= 1'b0;
        end else begin
            gfx_bank <= hit[busdec_pkg::IDX_GFX] & addr[GFX_BANK_BIT];
        end
    end

endmodule

// File: rtl/busdec_chk.sv
// Module: assertion checker bound to addr_strobe_decoder. It relates
// the registered outputs to the bus inputs of the previous clock.
module busdec_chk #(
    parameter int NREG = busdec_pkg::NREG
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rw,
    input logic            phi2,
    input logic [NREG-1:0] ce_n,
    input logic [NREG-1:0] oe_n,
    input logic [NREG-1:0] we_n,
    input logic            dir_pull,
    input logic            buf_en_n,
    input logic            gfx_bank
);

    // R1
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    // R3
    oe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n != '1) |-> ($past(phi2) && $past(rw)));

    // R3
    oe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~oe_n) & ce_n) == '0);

    // R4
    we_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n != '1) |-> ($past(phi2) && !$past(rw) && (((~we_n) & ce_n) == '0)));

    // R6
    dir_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_pull |-> ((ce_n != '1) && $past(rw) && $past(phi2)));

    // R7
    buf_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en_n |-> ((ce_n != '1) && $past(phi2)));

    // R10
    bank_in_gfx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gfx_bank |-> !ce_n[busdec_pkg::IDX_GFX]);

endmodule

bind addr_strobe_decoder busdec_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rw       (rw),
    .phi2     (phi2),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dir_pull (dir_pull),
    .buf_en_n (buf_en_n),
    .gfx_bank (gfx_bank)
);

// File: tb/addr_strobe_decoder_test.sv
// Scoreboard bench. The driver applies the bus inputs at the falling
// edge and queues the expected outputs. The monitor compares them just
// after the next rising edge.
module addr_strobe_decoder_test;

    typedef struct {
        logic [7:0] ce_n;
        logic [7:0] oe_n;
        logic [7:0] we_n;
        logic       dir_pull;
        logic       buf_en_n;
        logic       gfx_bank;
        logic [7:0] bus_rdata;
        logic [7:0] loc_wdata;
        logic [15:0] a;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'hFE00;
    logic        rw = 1'b1;
    logic        phi2 = 1'b1;
    logic [7:0]  loc_rdata = 8'h5A;
    logic [7:0]  bus_wdata = 8'h3C;
    logic [7:0]  ce_n, oe_n, we_n, bus_rdata, loc_wdata;
    logic        dir_pull, buf_en_n, gfx_bank;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    addr_strobe_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .phi2(phi2),
        .loc_rdata(loc_rdata), .bus_wdata(bus_wdata),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dir_pull(dir_pull),
        .buf_en_n(buf_en_n), .gfx_bank(gfx_bank),
        .bus_rdata(bus_rdata), .loc_wdata(loc_wdata)
    );

    // One comparison; prints FAIL with the requirement on a mismatch.
    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input logic [15:0] a);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, act, exp);
        end
    endtask

    // Region index from the map (8 = none), written out independently.
    function automatic int region_of(input logic [15:0] a);
        if (a >= 16'hFE00)                     return 0;
        if (a >= 16'hFC00 && a <= 16'hFCFF)    return 1;
        if (a >= 16'hE000 && a <= 16'hE3FF)    return 2;
        if (a >= 16'hE400 && a <= 16'hE7FF)    return 3;
        if (a >= 16'hDC00 && a <= 16'hDFFF)    return 4;
        if (a >= 16'hD400 && a <= 16'hDBFF)    return 5;
        if (a >= 16'hD000 && a <= 16'hD3FF)    return 6;
        if (a <= 16'h0FFF)                     return 7;
        return 8;
    endfunction

    // Driver: apply one bus cycle and queue its expected outputs.
    task automatic drive(input logic [15:0] a, input logic r, input logic p);
        exp_t e;
        int   idx;
        logic hitv, wr_ok;
        @(negedge clk);
        addr      = a;
        rw        = r;
        phi2      = p;
        loc_rdata = 8'($urandom);
        bus_wdata = 8'($urandom);
        idx   = region_of(a);
        hitv  = (idx != 8);
        wr_ok = (idx == 1) || (idx == 5) || (idx == 6) || (idx == 7);
        e.a         = a;
        e.ce_n      = hitv ? ~(8'h01 << idx) : 8'hFF;
        e.oe_n      = (hitv && p && r) ? ~(8'h01 << idx) : 8'hFF;
        e.we_n      = (hitv && p && !r && wr_ok) ? ~(8'h01 << idx) : 8'hFF;
        e.dir_pull  = hitv && p && r;
        e.buf_en_n  = !(hitv && p);
        e.gfx_bank  = (idx == 5) ? a[10] : 1'b0;
        e.bus_rdata = (hitv && p && r) ? ~loc_rdata : 8'hFF;
        e.loc_wdata = ~bus_wdata;
        sb.push_back(e);
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check("R1/R2/R5 ce_n", 32'(ce_n), 32'(e.ce_n), e.a);
            check("R3 oe_n", 32'(oe_n), 32'(e.oe_n), e.a);
            check("R4 we_n", 32'(we_n), 32'(e.we_n), e.a);
            check("R6 dir_pull", 32'(dir_pull), 32'(e.dir_pull), e.a);
            check("R7 buf_en_n", 32'(buf_en_n), 32'(e.buf_en_n), e.a);
            check("R10 gfx_bank", 32'(gfx_bank), 32'(e.gfx_bank), e.a);
            check("R8 bus_rdata", 32'(bus_rdata), 32'(e.bus_rdata), e.a);
            check("R9 loc_wdata", 32'(loc_wdata), 32'(e.loc_wdata), e.a);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] edges [24] = '{
            16'h0000, 16'h0FFF, 16'h1000, 16'hCFFF, 16'hD000, 16'hD3FF,
            16'hD400, 16'hD7FF, 16'hD800, 16'hDBFF, 16'hDC00, 16'hDFFF,
            16'hE000, 16'hE3FF, 16'hE400, 16'hE7FF, 16'hE800, 16'hFBFF,
            16'hFC00, 16'hFCFF, 16'hFD00, 16'hFDFF, 16'hFE00, 16'hFFFF};
        // R11: reset held with a qualified read hit on the inputs.
        repeat (3) @(posedge clk);
        #1;
        check("R11 ce_n", 32'(ce_n), 32'hFF, addr);
        check("R11 oe_n", 32'(oe_n), 32'hFF, addr);
        check("R11 we_n", 32'(we_n), 32'hFF, addr);
        check("R11 dir_pull", 32'(dir_pull), 32'h0, addr);
        check("R11 buf_en_n", 32'(buf_en_n), 32'h1, addr);
        check("R11 gfx_bank", 32'(gfx_bank), 32'h0, addr);
        check("R11 bus_rdata", 32'(bus_rdata), 32'hFF, addr);
        check("R11 loc_wdata", 32'(loc_wdata), 32'h00, addr);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 R2 R5 R10: every boundary under all phase and direction mixes.
        for (int i = 0; i < 24; i++) begin
            for (int m = 0; m < 4; m++) begin
                drive(edges[i], m[0], m[1]);
            end
        end
        // R4: writes to the read-only regions in phase 2.
        drive(16'hDC10, 1'b0, 1'b1);
        drive(16'hFE80, 1'b0, 1'b1);
        drive(16'hE123, 1'b0, 1'b1);
        // Random addresses and cycle types.
        for (int k = 0; k < 400; k++) begin
            drive(16'($urandom), 1'($urandom), 1'($urandom));
        end
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule